// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the 32 inputs of one GPIO bank and turns selected input activity into a single interrupt request. Each pin has its own trigger setting. It can fire on a rising edge, a falling edge, either edge, a high level or a low level. Detected events are held in a sticky status register until software clears them. A separate mask register decides which held events reach the interrupt output.

The pin inputs must already be synchronised to `clk`. Software uses a simple register port with one write channel and one combinational read channel. The port gives access to three configuration registers (detect kind, polarity, dual-edge), the status register (write 1 to clear), two write-only ports that unmask or mask pins, and a read-only view of the mask. Event capture does not depend on masking. An event that arrives while its pin is masked is held in status, and it raises the interrupt as soon as the pin is unmasked.

Top module: `gpio_irq_detect`

## Requirements
- R1: A 1 in the detect-kind register (offset 0) makes that pin edge-triggered. A 0 makes it level-triggered.
- R2: A 1 in the polarity register (offset 1) selects a rising edge or a high level. A 0 selects a falling edge or a low level.
- R3: When a pin is edge-triggered and its dual-edge bit (offset 2) is 1, the pin triggers on both edges and its polarity bit is ignored. For a level-triggered pin the dual-edge bit has no effect.
- R4: Writing to the status register (offset 3) clears each bit written as 1. Bits written as 0 keep their value. A read of offset 3 returns the status.
- R5: Writing to the unmask port (offset 4) clears the mask bit of each pin written as 1. Bits written as 0 leave the mask unchanged. A read of offset 4 returns 0.
- R6: Writing to the mask port (offset 5) sets the mask bit of each pin written as 1, so an all-ones write masks every pin. A read of offset 5 returns 0.
- R7: Reading offset 6 returns the mask, with a 1 for each masked pin. Writes to offset 6 are ignored, and offset 7 reads as 0.
- R8: A masked pin still captures events into its status bit. If the bit is still set when the pin is unmasked, the interrupt output rises in the cycle after the unmask write.
- R9: The interrupt output is 1 exactly when at least one pin has its status bit set and its mask bit clear.
- R10: An edge is detected by comparing the input at a clock edge with the value sampled at the previous clock edge, and the status bit is set at that same clock edge. A level-triggered pin whose level is active sets its status bit at every clock edge, including the clock edge of a clear write.
- R11: After reset, every pin is masked, the status, detect-kind, polarity and dual-edge registers are all zero, and the previous-sample copy of the pins is zero.
- R12: If a detection and a write-1-to-clear hit the same status bit at the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 32 | Synchronised pin levels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write offset |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read offset |
| rdData | output | 32 | Combinational read data |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A status bit can be set by a detection and cleared by a write-1-to-clear at the same clock edge. The bench provokes this in two ways. It holds a level-triggered pin active while clearing its bit, and it drives a rising edge on a pin in the same cycle as a write that clears that pin's bit. In both cases it expects the bit to read back as 1 afterwards. A second overlap is capture on a masked pin followed by an unmask write. The bench judges it by checking that the interrupt output stays low while the event is held, then goes high exactly one cycle after the write. A behavioural model running alongside compares the interrupt and the read port at every cycle, including during a stretch of random pin activity and register writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] OFS_KIND   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] OFS_POL    = 3'd1;
  localparam logic [REG_ADDR_W-1:0] OFS_DUAL   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 3'd3;
  localparam logic [REG_ADDR_W-1:0] OFS_UNMASK = 3'd4;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK   = 3'd5;
  localparam logic [REG_ADDR_W-1:0] OFS_MASKRD = 3'd6;

  typedef struct packed {
    logic wrKind;
    logic wrPol;
    logic wrDual;
    logic clrStatus;
    logic doUnmask;
    logic doMask;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    SEL_KIND,
    SEL_POL,
    SEL_DUAL,
    SEL_STATUS,
    SEL_MASK,
    SEL_ZERO
  } readSel_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobes_t      strobes,
  output readSel_t          rdSel
);

  // write decode: one strobe per writable offset
  always_comb begin
    strobes           = '0;
    strobes.wrKind    = wrEn && (wrAddr == ADDR_W'(OFS_KIND));
    strobes.wrPol     = wrEn && (wrAddr == ADDR_W'(OFS_POL));
    strobes.wrDual    = wrEn && (wrAddr == ADDR_W'(OFS_DUAL));
    strobes.clrStatus = wrEn && (wrAddr == ADDR_W'(OFS_STATUS));
    strobes.doUnmask  = wrEn && (wrAddr == ADDR_W'(OFS_UNMASK));
    strobes.doMask    = wrEn && (wrAddr == ADDR_W'(OFS_MASK));
  end

  // read decode: write-only and unused offsets read as zero
  always_comb begin
    if (rdAddr == ADDR_W'(OFS_KIND))        rdSel = SEL_KIND;
    else if (rdAddr == ADDR_W'(OFS_POL))    rdSel = SEL_POL;
    else if (rdAddr == ADDR_W'(OFS_DUAL))   rdSel = SEL_DUAL;
    else if (rdAddr == ADDR_W'(OFS_STATUS)) rdSel = SEL_STATUS;
    else if (rdAddr == ADDR_W'(OFS_MASKRD)) rdSel = SEL_MASK;
    else                                    rdSel = SEL_ZERO;
  end

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobes == '0)); // R7
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes)); // R7

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] wrData,
  input  ctrlStrobes_t        strobes,
  input  readSel_t            rdSel,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] kindQ, polQ, dualQ, statusQ, maskQ, pinDlyQ;
  logic [NUM_PINS-1:0] detect, clrVec, unmaskVec, maskVec;

  assign clrVec    = strobes.clrStatus ? wrData : '0;
  assign unmaskVec = strobes.doUnmask  ? wrData : '0;
  assign maskVec   = strobes.doMask    ? wrData : '0;

  // per-pin trigger selection
  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic riseHit, fallHit, edgeHit, levelHit;
    assign riseHit  = pinIn[gi] & ~pinDlyQ[gi];
    assign fallHit  = ~pinIn[gi] & pinDlyQ[gi];
    assign edgeHit  = dualQ[gi] ? (riseHit | fallHit)
                                : (polQ[gi] ? riseHit : fallHit);
    assign levelHit = polQ[gi] ? pinIn[gi] : ~pinIn[gi];
    assign detect[gi] = kindQ[gi] ? edgeHit : levelHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= '0;
      polQ    <= '0;
      dualQ   <= '0;
      statusQ <= '0;
      maskQ   <= '1;
      pinDlyQ <= '0;
    end else begin
      pinDlyQ <= pinIn;
      statusQ <= (statusQ & ~clrVec) | detect;
      maskQ   <= (maskQ & ~unmaskVec) | maskVec;
      if (strobes.wrKind) kindQ <= wrData;
      if (strobes.wrPol)  polQ  <= wrData;
      if (strobes.wrDual) dualQ <= wrData;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_KIND:   rdData = kindQ;
      SEL_POL:    rdData = polQ;
      SEL_DUAL:   rdData = dualQ;
      SEL_STATUS: rdData = statusQ;
      SEL_MASK:   rdData = maskQ;
      default:    rdData = '0;
    endcase
  end

  assign irqOut = |(statusQ & ~maskQ);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusQ) & ~statusQ) & ~$past(clrVec)) == '0)); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrStatus |=> ((statusQ & $past(wrData & ~detect)) == '0)); // R4
  AST_DETECT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((detect & clrVec) != '0) |=>
      ((statusQ & $past(detect & clrVec)) == $past(detect & clrVec))); // R12
  AST_UNMASK_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doUnmask |=> ((maskQ & $past(wrData)) == '0)); // R5
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doMask && (wrData == '1)) |=> ((maskQ == '1) && !irqOut)); // R6

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = REG_ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [NUM_PINS-1:0] rdData,
  output logic                irqOut
);

  ctrlStrobes_t strobes;
  readSel_t     rdSel;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .wrData  (wrData),
    .strobes (strobes),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

  AST_RESET_MASKED: assert property (@(posedge clk)
    !rstN |=> (!irqOut)); // R11

endmodule

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pinDrv = '0;
  logic         wrEnDrv = 1'b0;
  logic [2:0]   wrAddrDrv = '0;
  logic [N-1:0] wrDataDrv = '0;
  logic [2:0]   rdAddrDrv = '0;
  logic [N-1:0] rdData;
  logic         irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  bit [N-1:0] mKind, mPol, mDual, mStat, mMask, mPrev;

  always #10 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinDrv), .wrEn(wrEnDrv), .wrAddr(wrAddrDrv),
    .wrData(wrDataDrv), .rdAddr(rdAddrDrv), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic bit [N-1:0] modelRead(input int a);
    case (a)
      0: return mKind;
      1: return mPol;
      2: return mDual;
      3: return mStat;
      6: return mMask;
      default: return '0;
    endcase
  endfunction

  task automatic modelReset();
    mKind = '0; mPol = '0; mDual = '0; mStat = '0; mMask = '1; mPrev = '0;
  endtask

  task automatic modelUpdate();
    bit [N-1:0] hit;
    for (int i = 0; i < N; i++) begin
      bit r, f;
      r = pinDrv[i] && !mPrev[i];
      f = !pinDrv[i] && mPrev[i];
      if (mKind[i]) hit[i] = mDual[i] ? (r || f) : (mPol[i] ? r : f);
      else          hit[i] = mPol[i] ? pinDrv[i] : !pinDrv[i];
    end
    if (wrEnDrv && wrAddrDrv == 3) mStat = mStat & ~wrDataDrv;
    mStat = mStat | hit;
    if (wrEnDrv) begin
      case (wrAddrDrv)
        0: mKind = wrDataDrv;
        1: mPol  = wrDataDrv;
        2: mDual = wrDataDrv;
        4: mMask = mMask & ~wrDataDrv;
        5: mMask = mMask | wrDataDrv;
        default: ;
      endcase
    end
    mPrev = pinDrv;
  endtask

  task automatic check(input string tag, input bit [N-1:0] act, input bit [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareModel(input string tag);
    bit irqExp;
    irqExp = |(mStat & ~mMask);
    check({tag, " irq"}, {31'd0, irqOut}, {31'd0, irqExp});
    check({tag, " read"}, rdData, modelRead(int'(rdAddrDrv)));
  endtask

  int cyc = 0;
  task automatic step(input string tag);
    rdAddrDrv = 3'(cyc % 8);
    cyc++;
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compareModel(tag);
  endtask

  task automatic regWrite(input int a, input bit [N-1:0] d, input string tag);
    wrEnDrv = 1'b1; wrAddrDrv = 3'(a); wrDataDrv = d;
    step(tag);
    wrEnDrv = 1'b0; wrDataDrv = '0;
  endtask

  task automatic readCheck(input int a, input bit [N-1:0] exp, input string tag);
    rdAddrDrv = 3'(a);
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic irqCheck(input bit exp, input string tag);
    check(tag, {31'd0, irqOut}, {31'd0, exp});
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state, before any active edge
    readCheck(6, '1, "R11 mask after reset");
    readCheck(3, '0, "R11 status after reset");
    readCheck(0, '0, "R11 kind after reset");
    irqCheck(1'b0, "R11 irq after reset");

    // configuration: pins 3,4 level, rest edge; pin0 rising, pin3 high; pins 2,4 dual
    regWrite(0, 32'hFFFF_FFE7, "R1 kind write");
    regWrite(1, 32'h0000_0009, "R2 pol write");
    regWrite(2, 32'h0000_0014, "R3 dual write");
    readCheck(2, 32'h0000_0014, "R3 dual readback");
    regWrite(3, '1, "R4 clear all");
    readCheck(3, 32'h0000_0010, "R3 dual ignored on level-low pin4");
    regWrite(4, 32'h0000_000F, "R5 unmask 0-3");
    readCheck(6, 32'hFFFF_FFF0, "R7 mask view");
    readCheck(4, '0, "R5 unmask port reads zero");
    irqCheck(1'b0, "R9 only masked pending");

    pinDrv[0] = 1'b1; step("R10 rise pin0");
    readCheck(3, 32'h0000_0011, "R1 rising edge captured");
    irqCheck(1'b1, "R9 unmasked pending");
    regWrite(3, 32'h0000_0001, "R4 clear pin0");
    readCheck(3, 32'h0000_0010, "R4 pin0 cleared");
    pinDrv[0] = 1'b0; step("R2 fall on rising pin");
    readCheck(3, 32'h0000_0010, "R2 falling ignored on pin0");
    irqCheck(1'b0, "R9 none pending");

    pinDrv[1] = 1'b1; step("R2 rise pin1");
    pinDrv[1] = 1'b0; step("R2 fall pin1");
    readCheck(3, 32'h0000_0012, "R2 falling edge pin1");

    pinDrv[2] = 1'b1; step("R3 rise pin2");
    readCheck(3, 32'h0000_0016, "R3 dual rise pin2");
    regWrite(3, 32'h0000_0004, "R4 clear pin2");
    readCheck(3, 32'h0000_0012, "R4 zeros unaffected");
    pinDrv[2] = 1'b0; step("R3 fall pin2");
    readCheck(3, 32'h0000_0016, "R3 dual fall pin2");

    pinDrv[3] = 1'b1; step("R2 level high pin3");
    readCheck(3, 32'h0000_001E, "R2 level high pin3");
    regWrite(3, 32'h0000_0008, "R10 clear active level");
    readCheck(3, 32'h0000_001E, "R10 level re-sets after clear");
    pinDrv[3] = 1'b0; step("R10 release pin3");
    regWrite(3, 32'h0000_0008, "R10 clear idle level");
    readCheck(3, 32'h0000_0016, "R10 inactive level clears");

    regWrite(3, '1, "R4 clear all again");
    pinDrv[5] = 1'b1; step("R8 rise pin5");
    pinDrv[5] = 1'b0; step("R8 fall pin5 masked");
    readCheck(3, 32'h0000_0030, "R8 capture while masked");
    irqCheck(1'b0, "R8 masked quiet");
    regWrite(4, 32'h0000_0020, "R8 unmask pin5");
    irqCheck(1'b1, "R8 held event after unmask");
    readCheck(6, 32'hFFFF_FFD0, "R7 mask after unmask");

    // detection and clear on the same bit in one cycle
    pinDrv[0] = 1'b1;
    regWrite(3, 32'h0000_0001, "R12 rise with clear");
    readCheck(3, 32'h0000_0031, "R12 detection wins");

    regWrite(5, 32'h0000_0001, "R6 mask pin0");
    readCheck(6, 32'hFFFF_FFD1, "R6 partial mask");
    regWrite(6, '0, "R7 write to mask view");
    readCheck(6, 32'hFFFF_FFD1, "R7 mask view write ignored");
    readCheck(7, '0, "R7 offset 7 zero");
    regWrite(5, '1, "R6 mask all");
    readCheck(6, '1, "R6 all masked");
    irqCheck(1'b0, "R6 irq low when all masked");

    // random activity compared against the model every cycle
    for (int k = 0; k < 400; k++) begin
      pinDrv = pinDrv ^ ($urandom() & $urandom());
      if (($urandom() % 3) == 0) begin
        wrEnDrv = 1'b1;
        wrAddrDrv = 3'($urandom() % 8);
        wrDataDrv = $urandom();
      end
      step("R9 random");
      wrEnDrv = 1'b0;
    end

    finishRun();
  end

endmodule